// File: doc/BRIEF.md
# Low-Power Mode Controller

This block is a small state machine that holds the chip's power mode. Five modes exist: full-speed run, low-power run, stop, low-power stop, and a debug-held stop. The processor moves the machine toward sleep with a single-cycle deep-sleep strobe. A 3-bit stop select field, read when the strobe arrives, chooses the kind of stop. A wake interrupt may arrive asynchronously to the clock. It is synchronized inside the block and brings the machine back out of any stop state. A synchronous system reset returns the machine to full-speed run from any state.

The wake target from low-power stop depends on how that state was entered. If low-power stop was entered from low-power run, a wake returns to low-power run. If it was entered straight from full-speed run, the return to low-power run is blocked and a wake lands in full-speed run. A one-bit origin record kept with the state makes that choice.

A debugger can raise two power-up requests, one for the system and one for debug. While a debugger holds both requests, any sleep strobe that would have entered a stop state enters the debug-held stop instead. In that state the regulator and the clock stay in their run settings. Low-power run cannot be reached by the normal mode flow here. It is reached through a test hook input that is honoured only in full-speed run.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset is synchronous and active high, and it overrides every other input in the same cycle. The cycle after a reset edge, mode_code is 0 (full-speed run), reg_run and clk_en are 1, and the stored origin is cleared.
- R2: mode_code encodes the modes as 0 full-speed run, 1 low-power run, 2 stop, 3 low-power stop and 4 debug-held stop. In full-speed run with no sleep strobe, lprun_hook high moves the mode to 1 at the next edge.
- R3: In full-speed run with fewer than two debugger requests, a sleep strobe moves to low-power stop (3) at the next edge when stop_sel is 3'b010, and to stop (2) for every other stop_sel value.
- R4: In low-power run with fewer than two debugger requests, a sleep strobe with stop_sel equal to 3'b010 or 3'b000 moves to low-power stop at the next edge. With any other stop_sel, the strobe leaves the mode at 1.
- R5: wake_irq passes through SYNC_STAGES flip-flops, 2 by default. A wake held high in stop changes the mode to full-speed run on the (SYNC_STAGES+1)-th rising edge after wake_irq rises, and not before.
- R6: A wake in low-power stop returns to low-power run if that state was entered from low-power run, and to full-speed run if it was entered from full-speed run.
- R7: reg_run is 1 (run regulation) in modes 0 and 4 and is 0 in modes 1, 2 and 3. clk_en is 1 in modes 0, 1 and 4 and is 0 in modes 2 and 3.
- R8: In modes 0, 1 and 4, sys_pwr_ack follows sys_pwr_req and dbg_pwr_ack follows dbg_pwr_req combinationally. In modes 2 and 3, both acknowledges are 0.
- R9: With sys_pwr_req and dbg_pwr_req both high, a sleep strobe that R3 or R4 would turn into a stop entry moves to mode 4 instead. One request alone does not do this.
- R10: Mode 4 persists when the debugger requests drop. A wake returns it to the mode it was entered from (0 or 1), and a reset returns it to 0.
- R11: Sleep strobes and lprun_hook have no effect in modes 2, 3 and 4. A wake and lprun_hook have no effect in modes 0 and 1, except that lprun_hook in mode 0 acts as R2 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| sleep_req | input | 1 | Single-cycle deep-sleep entry strobe |
| stop_sel | input | 3 | Stop-kind select, read when the strobe arrives |
| wake_irq | input | 1 | Asynchronous wake interrupt, level |
| lprun_hook | input | 1 | Test hook that enters low-power run from full-speed run |
| sys_pwr_req | input | 1 | Debugger system power-up request |
| dbg_pwr_req | input | 1 | Debugger debug power-up request |
| mode_code | output | 3 | Current mode code |
| reg_run | output | 1 | 1 = run regulation, 0 = stop regulation |
| clk_en | output | 1 | Clock-source enable |
| sys_pwr_ack | output | 1 | System power-up acknowledge |
| dbg_pwr_ack | output | 1 | Debug power-up acknowledge |

## Verification
A wake and a reset can reach the state register in the same cycle. The bench provokes this in low-power stop entered from low-power run: it raises wake_irq, waits until the synchronized wake is live, and then asserts reset for exactly that edge. The result must be full-speed run and not the wake target, low-power run. A second collision applies a sleep strobe together with reset in full-speed run, and the mode must stay 0.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int MODE_W = 3;
    localparam int SEL_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_RUN     = 3'd0,
        PM_LPRUN   = 3'd1,
        PM_STOP    = 3'd2,
        PM_LPSTOP  = 3'd3,
        PM_EMUSTOP = 3'd4
    } pm_mode_e;

    localparam logic [SEL_W-1:0] SEL_LPSTOP = 3'b010;
    localparam logic [SEL_W-1:0] SEL_ALT    = 3'b000;

    typedef struct packed {
        pm_mode_e mode;
        logic     back_lp;   // 1: stop state was entered from low-power run
    } pm_state_t;

    typedef struct packed {
        logic reg_run;
        logic clk_en;
    } pm_ctrl_t;

    typedef struct packed {
        logic sys;
        logic dbg;
    } pm_dbg_t;

    function automatic pm_ctrl_t mode_ctrl(input pm_mode_e m);
        pm_ctrl_t c;
        case (m)
            PM_RUN:     c = '{reg_run: 1'b1, clk_en: 1'b1};
            PM_LPRUN:   c = '{reg_run: 1'b0, clk_en: 1'b1};
            PM_EMUSTOP: c = '{reg_run: 1'b1, clk_en: 1'b1};
            default:    c = '{reg_run: 1'b0, clk_en: 1'b0};
        endcase
        return c;
    endfunction

    function automatic logic lp_sel_ok(input logic [SEL_W-1:0] sel);
        return (sel == SEL_LPSTOP) || (sel == SEL_ALT);
    endfunction

    function automatic logic acks_live(input pm_mode_e m);
        return (m == PM_RUN) || (m == PM_LPRUN) || (m == PM_EMUSTOP);
    endfunction

    function automatic pm_mode_e wake_target(input logic back_lp);
        return back_lp ? PM_LPRUN : PM_RUN;
    endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= async_in;
            end
            assign sync_out = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], async_in};
            end
            assign sync_out = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pwr_dbg_ack.sv
module pwr_dbg_ack
    import pwr_mode_pkg::*;
(
    input  pm_mode_e mode,
    input  pm_dbg_t  req,
    output pm_dbg_t  ack,
    output logic     hold
);
    always_comb begin
        ack.sys = req.sys & acks_live(mode);
        ack.dbg = req.dbg & acks_live(mode);
    end
    assign hold = req.sys & req.dbg;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [SEL_W-1:0] stop_sel,
    input  logic             wake,
    input  logic             dbg_hold,
    input  logic             lprun_hook,
    output pm_mode_e         mode
);
    pm_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        case (cur.mode)
            PM_RUN: begin
                if (sleep_req) begin
                    nxt.back_lp = 1'b0;
                    if (dbg_hold)                      nxt.mode = PM_EMUSTOP;
                    else if (stop_sel == SEL_LPSTOP)   nxt.mode = PM_LPSTOP;
                    else                               nxt.mode = PM_STOP;
                end else if (lprun_hook) begin
                    nxt.mode = PM_LPRUN;
                end
            end
            PM_LPRUN: begin
                if (sleep_req && lp_sel_ok(stop_sel)) begin
                    nxt.back_lp = 1'b1;
                    nxt.mode    = dbg_hold ? PM_EMUSTOP : PM_LPSTOP;
                end
            end
            PM_STOP: begin
                if (wake) nxt.mode = PM_RUN;
            end
            PM_LPSTOP, PM_EMUSTOP: begin
                if (wake) nxt.mode = wake_target(cur.back_lp);
            end
            default: nxt = '{mode: PM_RUN, back_lp: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '{mode: PM_RUN, back_lp: 1'b0};
        else     cur <= nxt;
    end

    assign mode = cur.mode;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [SEL_W-1:0] stop_sel,
    input  logic             wake_irq,
    input  logic             lprun_hook,
    input  logic             sys_pwr_req,
    input  logic             dbg_pwr_req,
    output logic [MODE_W-1:0] mode_code,
    output logic             reg_run,
    output logic             clk_en,
    output logic             sys_pwr_ack,
    output logic             dbg_pwr_ack
);
    logic     wake_s;
    logic     dbg_hold;
    pm_mode_e mode;
    pm_dbg_t  req, ack;
    pm_ctrl_t ctrl;

    pwr_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wake_irq),
        .sync_out (wake_s)
    );

    assign req = '{sys: sys_pwr_req, dbg: dbg_pwr_req};

    pwr_dbg_ack u_ack (
        .mode (mode),
        .req  (req),
        .ack  (ack),
        .hold (dbg_hold)
    );

    pwr_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .stop_sel   (stop_sel),
        .wake       (wake_s),
        .dbg_hold   (dbg_hold),
        .lprun_hook (lprun_hook),
        .mode       (mode)
    );

    assign ctrl        = mode_ctrl(mode);
    assign mode_code   = mode;
    assign reg_run     = ctrl.reg_run;
    assign clk_en      = ctrl.clk_en;
    assign sys_pwr_ack = ack.sys;
    assign dbg_pwr_ack = ack.dbg;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
    import pwr_mode_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sleep_req,
    input logic [SEL_W-1:0]  stop_sel,
    input logic              wake_s,
    input logic              sys_pwr_req,
    input logic              dbg_pwr_req,
    input logic [MODE_W-1:0] mode_code,
    input logic              reg_run,
    input logic              clk_en,
    input logic              sys_pwr_ack,
    input logic              dbg_pwr_ack
);
    logic both;
    assign both = sys_pwr_req & dbg_pwr_req;

    p_reset_run_r1: assert property (@(posedge clk)
        rst |=> (mode_code == PM_RUN));

    p_run_lpstop_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_RUN && sleep_req && stop_sel == SEL_LPSTOP && !both)
        |=> (mode_code == PM_LPSTOP));

    p_lprun_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_LPRUN && sleep_req && lp_sel_ok(stop_sel) && !both)
        |=> (mode_code == PM_LPSTOP));

    p_stop_wake_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_STOP && wake_s) |=> (mode_code == PM_RUN));

    p_lpstop_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_LPSTOP) |-> (!reg_run && !clk_en));

    p_emu_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_EMUSTOP) |-> (reg_run && clk_en));

    p_ack_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_STOP || mode_code == PM_LPSTOP)
        |-> (!sys_pwr_ack && !dbg_pwr_ack));

    p_emu_entry_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_RUN && sleep_req && both) |=> (mode_code == PM_EMUSTOP));

    p_emu_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_EMUSTOP && !wake_s) |=> (mode_code == PM_EMUSTOP));

    p_stop_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_code == PM_STOP && !wake_s) |=> (mode_code == PM_STOP));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep_req   (sleep_req),
    .stop_sel    (stop_sel),
    .wake_s      (wake_s),
    .sys_pwr_req (sys_pwr_req),
    .dbg_pwr_req (dbg_pwr_req),
    .mode_code   (mode_code),
    .reg_run     (reg_run),
    .clk_en      (clk_en),
    .sys_pwr_ack (sys_pwr_ack),
    .dbg_pwr_ack (dbg_pwr_ack)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/100ps
module pwr_mode_ctrl_test;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst, sleep_req, wake_irq, lprun_hook, sys_pwr_req, dbg_pwr_req;
    logic [2:0] stop_sel;
    logic [2:0] mode_code;
    logic       reg_run, clk_en, sys_pwr_ack, dbg_pwr_ack;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .stop_sel(stop_sel),
        .wake_irq(wake_irq), .lprun_hook(lprun_hook),
        .sys_pwr_req(sys_pwr_req), .dbg_pwr_req(dbg_pwr_req),
        .mode_code(mode_code), .reg_run(reg_run), .clk_en(clk_en),
        .sys_pwr_ack(sys_pwr_ack), .dbg_pwr_ack(dbg_pwr_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sleep_req = 1'b0; wake_irq = 1'b0; lprun_hook = 1'b0;
        sys_pwr_req = 1'b0; dbg_pwr_req = 1'b0; stop_sel = 3'b000;
        tick();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int exp_reg(input int m);
        return (m == 0 || m == 4) ? 1 : 0;
    endfunction
    function automatic int exp_clk(input int m);
        return (m <= 1 || m == 4) ? 1 : 0;
    endfunction
    function automatic int live(input int m);
        return (m <= 1 || m == 4) ? 1 : 0;
    endfunction

    task automatic enter(input int st, input int sel, input int dq);
        do_reset();
        if (st == 1) begin
            lprun_hook = 1'b1;
            tick();
            @(negedge clk);
            lprun_hook = 1'b0;
            chk("R2 hook to low-power run", mode_code, 1);
        end
        sleep_req = 1'b1; stop_sel = sel[2:0];
        sys_pwr_req = dq[1]; dbg_pwr_req = dq[0];
        tick();
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sleep_req = 1'b0; wake_irq = 1'b0; lprun_hook = 1'b0;
        sys_pwr_req = 1'b0; dbg_pwr_req = 1'b0; stop_sel = 3'b000;
        do_reset();
        #1;
        chk("R1 mode", mode_code, 0);
        chk("R1 reg_run", reg_run, 1);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 sys ack", sys_pwr_ack, 0);
        chk("R1 dbg ack", dbg_pwr_ack, 0);

        // combinational acks in full-speed run
        sys_pwr_req = 1'b1; #1;
        chk("R8 sys ack in run", sys_pwr_ack, 1);
        chk("R8 dbg ack in run", dbg_pwr_ack, 0);

        // sweep: origin x select x debugger requests
        for (int st = 0; st < 2; st++) begin
            for (int sel = 0; sel < 8; sel++) begin
                for (int dq = 0; dq < 4; dq++) begin
                    int exp, tgt;
                    string tag;
                    bit ok;
                    ok = (sel == 2) || (sel == 0);
                    if (st == 0) exp = (dq == 3) ? 4 : ((sel == 2) ? 3 : 2);
                    else         exp = !ok ? 1 : ((dq == 3) ? 4 : 3);
                    tag = (exp == 4) ? "R9" : ((st == 0) ? "R3" : "R4");
                    enter(st, sel, dq);
                    chk(tag, mode_code, exp);
                    chk("R7 reg_run", reg_run, exp_reg(exp));
                    chk("R7 clk_en", clk_en, exp_clk(exp));
                    chk("R8 sys ack", sys_pwr_ack, live(exp) & ((dq >> 1) & 1));
                    chk("R8 dbg ack", dbg_pwr_ack, live(exp) & (dq & 1));
                    if (exp != 1) begin
                        sleep_req = 1'b1; stop_sel = 3'b010; lprun_hook = 1'b1;
                        sys_pwr_req = 1'b0; dbg_pwr_req = 1'b0;
                        tick();
                        @(negedge clk);
                        sleep_req = 1'b0; lprun_hook = 1'b0;
                        chk((exp == 4) ? "R10 request drop" : "R11 strobe ignored", mode_code, exp);
                    end
                    wake_irq = 1'b1;
                    for (int k = 0; k < SYNC; k++) tick();
                    chk("R5 sync latency", mode_code, exp);
                    tick();
                    if (exp == 2)      tgt = 0;
                    else if (exp == 1) tgt = 1;
                    else               tgt = st;
                    chk((exp == 2) ? "R5" : (exp == 3) ? "R6" : (exp == 4) ? "R10" : "R11",
                        mode_code, tgt);
                    @(negedge clk);
                    wake_irq = 1'b0; sys_pwr_req = 1'b0; dbg_pwr_req = 1'b0;
                end
            end
        end

        // wake has no effect in full-speed run
        do_reset();
        wake_irq = 1'b1;
        repeat (SYNC + 2) tick();
        chk("R11 wake in run", mode_code, 0);

        // collision: reset and synchronized wake together in low-power stop
        enter(1, 0, 0);
        chk("R4 sel 000", mode_code, 3);
        wake_irq = 1'b1;
        repeat (SYNC) tick();
        @(negedge clk);
        rst = 1'b1;
        tick();
        chk("R1 reset beats wake", mode_code, 0);
        @(negedge clk);
        rst = 1'b0; wake_irq = 1'b0;
        repeat (SYNC + 1) tick();
        chk("R1 stays run", mode_code, 0);

        // collision: reset and sleep strobe together
        @(negedge clk);
        rst = 1'b1; sleep_req = 1'b1; stop_sel = 3'b010;
        tick();
        @(negedge clk);
        rst = 1'b0; sleep_req = 1'b0;
        chk("R1 reset beats sleep", mode_code, 0);

        // reset leaves debug-held stop entered from low-power run
        enter(1, 2, 3);
        chk("R9 from low-power run", mode_code, 4);
        rst = 1'b1;
        tick();
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset from held stop", mode_code, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule